// File: doc/BRIEF.md
# Dual-Bank Fast/Normal Interrupt Router

This block gathers forty level-sensitive interrupt sources into two 32-bit banks. Sources 0 to 31 occupy bank 0. Sources 32 to 39 occupy the low eight bits of bank 1. Each bank holds an enable mask and a steering register, and each steering bit sends its source either to the fast request (`fiq_o`) or to the normal request (`irq_o`). A third output, `wake_o`, tells a halted core that something is waiting. Its qualification is set by a one-bit idle policy: either every pending source may wake the core, or only enabled ones may.

Software reaches the state through a simple word port with valid, write, address and data signals. Reads return data one cycle after the request and are flagged by `rvalid_o`. Besides the raw level view, each bank offers two filtered views: pending, enabled and steered to normal, and pending, enabled and steered to fast. The highest-priority word is produced by a separate resolver and is only passed through on reads.

Top module: `pic_dual_bank`

## Requirements
- R1: A source's pending bit equals its input level, with no latching. The raw views at 0x10 (bank 0) and 0xAC (bank 1) return current levels. Bits 31:8 of every bank-1 register read as zero.
- R2: `fiq_o` is the OR over both banks of pending AND enabled AND steer. It is visible at the clock edge after the change. A steer bit of 1 selects the fast request.
- R3: `irq_o` is the OR over both banks of pending AND enabled AND NOT steer. No source contributes to both requests at once.
- R4: While `halted_i` is high, `wake_o` rises one edge later when any source is pending AND (enabled OR override). The override covers all sources when the control bit is 0 and none when it is 1. `wake_o` is low while not halted.
- R5: A write to the control register at 0x14 keeps only bit 0. A read returns that bit: 1 means only enabled sources may wake. The bit resets to 0.
- R6: Reads at 0x00 and 0x9C return pending AND enabled AND NOT steer. Reads at 0x0C and 0xA8 return pending AND enabled AND steer.
- R7: The masks (0x04, 0xA0) and steering registers (0x08, 0xA4) take a write at the next edge and read back what was stored. Bank 1 stores only bits 7:0.
- R8: Reset clears both masks, both steering registers and the control bit, and drives all three requests low.
- R9: Writes to the pending views, to 0x18 and to unmapped offsets change nothing. Unmapped offsets read as zero.
- R10: A read request returns data with `rvalid_o` high on the cycle after it. Offset 0x18 returns `hp_word_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 40 | Source levels, bit n is source n |
| halted_i | input | 1 | Core is halted |
| hp_word_i | input | 32 | Highest-priority word from the external resolver |
| req_i | input | 1 | Register access valid |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| wake_o | output | 1 | Wake request to a halted core |

## Verification
A table of patterns sets the sources, masks, steering, idle bit and halt state, then compares all three requests.

- A single source is tried in each bank, steered first one way and then the other. This separates the fast path from the normal path and shows that bank-1 bits reach the outputs.
- A masked source with the idle bit at 0 and then at 1 separates the override from plain enabling.
- A mixed pattern with one fast and one normal source raises both requests at once.
- All sources high with both masks clear shows that pending alone raises nothing.

Directed reads then check the filtered views, the bank-1 width limit and the control bit. Writes to read-only and unmapped offsets are followed by reads of the state they might have disturbed.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_IRQP0  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MASK0  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_STEER0 = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_FIQP0  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_RAW0   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CTL    = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_HP     = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_IRQP1  = 8'h9C;
  localparam logic [ADDR_W-1:0] OFF_MASK1  = 8'hA0;
  localparam logic [ADDR_W-1:0] OFF_STEER1 = 8'hA4;
  localparam logic [ADDR_W-1:0] OFF_FIQP1  = 8'hA8;
  localparam logic [ADDR_W-1:0] OFF_RAW1   = 8'hAC;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_IRQP, SEL_MASK, SEL_STEER, SEL_FIQP, SEL_RAW, SEL_CTL, SEL_HP
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e sel;
    logic     bank;
  } reg_dec_t;
endpackage

// File: rtl/pic_decode.sv
module pic_decode
  import pic_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output reg_dec_t          dec_o
);
  always_comb begin
    dec_o = '{sel: SEL_NONE, bank: 1'b0};
    unique case (addr_i)
      OFF_IRQP0:  dec_o = '{sel: SEL_IRQP,  bank: 1'b0};
      OFF_MASK0:  dec_o = '{sel: SEL_MASK,  bank: 1'b0};
      OFF_STEER0: dec_o = '{sel: SEL_STEER, bank: 1'b0};
      OFF_FIQP0:  dec_o = '{sel: SEL_FIQP,  bank: 1'b0};
      OFF_RAW0:   dec_o = '{sel: SEL_RAW,   bank: 1'b0};
      OFF_CTL:    dec_o = '{sel: SEL_CTL,   bank: 1'b0};
      OFF_HP:     dec_o = '{sel: SEL_HP,    bank: 1'b0};
      OFF_IRQP1:  dec_o = '{sel: SEL_IRQP,  bank: 1'b1};
      OFF_MASK1:  dec_o = '{sel: SEL_MASK,  bank: 1'b1};
      OFF_STEER1: dec_o = '{sel: SEL_STEER, bank: 1'b1};
      OFF_FIQP1:  dec_o = '{sel: SEL_FIQP,  bank: 1'b1};
      OFF_RAW1:   dec_o = '{sel: SEL_RAW,   bank: 1'b1};
      default:    dec_o = '{sel: SEL_NONE,  bank: 1'b0};
    endcase
  end
endmodule

// File: rtl/pic_bank.sv
module pic_bank
  import pic_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     src_i,
  input  logic             mask_we_i,
  input  logic             steer_we_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             ovr_i,
  output logic [REG_W-1:0] raw_o,
  output logic [REG_W-1:0] mask_o,
  output logic [REG_W-1:0] steer_o,
  output logic [REG_W-1:0] irq_vec_o,
  output logic [REG_W-1:0] fiq_vec_o,
  output logic             wake_any_o
);
  logic [W-1:0] mask_q, steer_q;
  logic [W-1:0] act, irq_v, fiq_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      steer_q <= '0;
    end else begin
      if (mask_we_i)  mask_q  <= wdata_i;
      if (steer_we_i) steer_q <= wdata_i;
    end
  end

  assign act        = src_i & mask_q;
  assign irq_v      = act & ~steer_q;
  assign fiq_v      = act & steer_q;
  // idle override lets masked sources wake the core
  assign wake_any_o = |(src_i & (mask_q | {W{ovr_i}}));

  always_comb begin
    raw_o     = '0;
    mask_o    = '0;
    steer_o   = '0;
    irq_vec_o = '0;
    fiq_vec_o = '0;
    raw_o[W-1:0]     = src_i;
    mask_o[W-1:0]    = mask_q;
    steer_o[W-1:0]   = steer_q;
    irq_vec_o[W-1:0] = irq_v;
    fiq_vec_o[W-1:0] = fiq_v;
  end

  // R3
  src_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_vec_o & fiq_vec_o) == '0);

  // R7
  mask_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_q == $past(wdata_i));

  // R7
  steer_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steer_we_i |=> steer_q == $past(wdata_i));
endmodule

// File: rtl/pic_req_out.sv
module pic_req_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halted_i,
  input  logic fiq_any_i,
  input  logic irq_any_i,
  input  logic wake_any_i,
  output logic fiq_o,
  output logic irq_o,
  output logic wake_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fiq_o  <= 1'b0;
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      fiq_o  <= fiq_any_i;
      irq_o  <= irq_any_i;
      wake_o <= halted_i & wake_any_i;
    end
  end

  // R4
  wake_needs_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(halted_i));
endmodule

// File: rtl/pic_dual_bank.sv
module pic_dual_bank
  import pic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SRC-1:0]    src_i,
  input  logic                  halted_i,
  input  logic [REG_W-1:0]      hp_word_i,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic [REG_W-1:0]      rdata_o,
  output logic                  rvalid_o,
  output logic                  fiq_o,
  output logic                  irq_o,
  output logic                  wake_o
);
  localparam int unsigned NBANK = 2;
  localparam int unsigned HI_W  = NUM_SRC - REG_W;

  reg_dec_t         dec;
  logic             wr, rd, ctl_q;
  logic [REG_W-1:0] raw   [NBANK];
  logic [REG_W-1:0] mask  [NBANK];
  logic [REG_W-1:0] steer [NBANK];
  logic [REG_W-1:0] irqv  [NBANK];
  logic [REG_W-1:0] fiqv  [NBANK];
  logic [NBANK-1:0] wake_b;
  logic [REG_W-1:0] rd_mux;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  pic_decode u_dec (.addr_i(addr_i), .dec_o(dec));

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int unsigned W  = (b == 0) ? REG_W : HI_W;
    localparam int unsigned LO = b * REG_W;
    logic mask_we, steer_we;
    assign mask_we  = wr && dec.sel == SEL_MASK  && dec.bank == 1'(b);
    assign steer_we = wr && dec.sel == SEL_STEER && dec.bank == 1'(b);
    pic_bank #(.W(W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_i[LO+W-1:LO]),
      .mask_we_i  (mask_we),
      .steer_we_i (steer_we),
      .wdata_i    (wdata_i[W-1:0]),
      .ovr_i      (~ctl_q),
      .raw_o      (raw[b]),
      .mask_o     (mask[b]),
      .steer_o    (steer[b]),
      .irq_vec_o  (irqv[b]),
      .fiq_vec_o  (fiqv[b]),
      .wake_any_o (wake_b[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ctl_q <= 1'b0;
    else if (wr && dec.sel == SEL_CTL)  ctl_q <= wdata_i[0];
  end

  always_comb begin
    unique case (dec.sel)
      SEL_IRQP:  rd_mux = irqv[dec.bank];
      SEL_MASK:  rd_mux = mask[dec.bank];
      SEL_STEER: rd_mux = steer[dec.bank];
      SEL_FIQP:  rd_mux = fiqv[dec.bank];
      SEL_RAW:   rd_mux = raw[dec.bank];
      SEL_CTL:   rd_mux = {{(REG_W-1){1'b0}}, ctl_q};
      SEL_HP:    rd_mux = hp_word_i;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux;
    end
  end

  pic_req_out u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .halted_i   (halted_i),
    .fiq_any_i  (|(fiqv[0] | fiqv[1])),
    .irq_any_i  (|(irqv[0] | irqv[1])),
    .wake_any_i (|wake_b),
    .fiq_o      (fiq_o),
    .irq_o      (irq_o),
    .wake_o     (wake_o)
  );

  // R5
  ctl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && dec.sel == SEL_CTL) |=> ctl_q == $past(wdata_i[0]));

  // R10
  rvalid_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));
endmodule

// File: tb/tb_pic_dual_bank.sv
module tb_pic_dual_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [39:0] src = '0;
  logic        halted = 1'b0;
  logic [31:0] hp_word = 32'h8005_0003;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, fiq, irq, wake;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_dual_bank dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .halted_i(halted),
    .hp_word_i(hp_word), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .fiq_o(fiq), .irq_o(irq), .wake_o(wake)
  );

  typedef struct packed {
    logic [39:0] src;
    logic [31:0] m0;
    logic [7:0]  m1;
    logic [31:0] s0;
    logic [7:0]  s1;
    logic        ctl;
    logic        halt;
    logic        ef;
    logic        ei;
    logic        ew;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{40'h0,            32'hFFFF_FFFF, 8'hFF, 32'h0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{40'h1,            32'h1,         8'h00, 32'h0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{40'h1,            32'h1,         8'h00, 32'h1, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{40'h08_0000_0000, 32'h0,         8'h08, 32'h0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{40'h08_0000_0000, 32'h0,         8'h08, 32'h0, 8'h08, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{40'h20,           32'h0,         8'h00, 32'h0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{40'h20,           32'h0,         8'h00, 32'h0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{40'h80_0000_0008, 32'h8,         8'h80, 32'h8, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    '{40'hFF_FFFF_FFFF, 32'h0,         8'h00, 32'h0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    if (rvalid !== 1'b1) begin
      checks++; fails++;
      $display("FAIL R10 rvalid act=%b exp=1", rvalid);
    end
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R8 reset state
    check("R8 fiq", {31'b0, fiq}, 0);
    check("R8 irq", {31'b0, irq}, 0);
    check("R8 wake", {31'b0, wake}, 0);
    bus_rd(8'h04, d); check("R8 mask0", d, 0);
    bus_rd(8'hA4, d); check("R8 steer1", d, 0);
    bus_rd(8'h14, d); check("R5 ctl reset", d, 0);

    // table walk: R2 R3 R4
    for (int i = 0; i < NVEC; i++) begin
      bus_wr(8'h04, VECS[i].m0);
      bus_wr(8'hA0, {24'h0, VECS[i].m1});
      bus_wr(8'h08, VECS[i].s0);
      bus_wr(8'hA4, {24'h0, VECS[i].s1});
      bus_wr(8'h14, {31'h0, VECS[i].ctl});
      @(negedge clk);
      src = VECS[i].src; halted = VECS[i].halt;
      repeat (2) @(negedge clk);
      check($sformatf("R2 fiq vec%0d", i), {31'b0, fiq}, {31'b0, VECS[i].ef});
      check($sformatf("R3 irq vec%0d", i), {31'b0, irq}, {31'b0, VECS[i].ei});
      check($sformatf("R4 wake vec%0d", i), {31'b0, wake}, {31'b0, VECS[i].ew});
    end

    // R2 one-edge latency
    bus_wr(8'h04, 32'h2); bus_wr(8'h08, 32'h2);
    bus_wr(8'hA0, 32'h0);
    src = 40'h0;
    repeat (2) @(negedge clk);
    src = 40'h2;
    @(negedge clk);
    check("R2 latency", {31'b0, fiq}, 1);

    // R1 raw views
    src = 40'hFF_1234_5678;
    @(negedge clk);
    bus_rd(8'h10, d); check("R1 raw0", d, 32'h1234_5678);
    bus_rd(8'hAC, d); check("R1 raw1", d, 32'h0000_00FF);

    // R6 filtered views
    src = 40'h03_0000_0003;
    bus_wr(8'h04, 32'h3); bus_wr(8'h08, 32'h2);
    bus_wr(8'hA0, 32'h3); bus_wr(8'hA4, 32'h1);
    bus_rd(8'h00, d); check("R6 irqp0", d, 32'h1);
    bus_rd(8'h0C, d); check("R6 fiqp0", d, 32'h2);
    bus_rd(8'h9C, d); check("R6 irqp1", d, 32'h2);
    bus_rd(8'hA8, d); check("R6 fiqp1", d, 32'h1);

    // R7 readback and bank-1 width
    bus_wr(8'hA0, 32'hFFFF_FFFF);
    bus_rd(8'hA0, d); check("R7 mask1 width", d, 32'h0000_00FF);
    bus_wr(8'h08, 32'hDEAD_BEEF);
    bus_rd(8'h08, d); check("R7 steer0", d, 32'hDEAD_BEEF);

    // R5 control bit 0 only
    bus_wr(8'h14, 32'hFFFF_FFFE);
    bus_rd(8'h14, d); check("R5 ctl clr", d, 0);
    bus_wr(8'h14, 32'h3);
    bus_rd(8'h14, d); check("R5 ctl set", d, 1);

    // R9 ignored writes
    bus_wr(8'h04, 32'h0000_00F0);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_wr(8'h40, 32'hFFFF_FFFF);
    bus_wr(8'h18, 32'hFFFF_FFFF);
    bus_rd(8'h10, d); check("R9 raw0 untouched", d, 32'h3);
    bus_rd(8'h04, d); check("R9 mask0 untouched", d, 32'h0000_00F0);
    bus_rd(8'h40, d); check("R9 unmapped read", d, 0);
    bus_rd(8'h14, d); check("R9 ctl untouched", d, 1);

    // R10 passthrough
    bus_rd(8'h18, d); check("R10 hp word", d, 32'h8005_0003);
    @(negedge clk);
    check("R10 rvalid idle", {31'b0, rvalid}, 0);

    // R8 mid-run reset
    bus_wr(8'h04, 32'h1); bus_wr(8'h08, 32'h0); src = 40'h1;
    repeat (2) @(negedge clk);
    check("R3 irq before reset", {31'b0, irq}, 1);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    check("R8 irq after reset", {31'b0, irq}, 0);
    bus_rd(8'h04, d); check("R8 mask0 after reset", d, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule